// File: doc/BRIEF.md
# Colored Button Code Lock

This block is a synchronous state machine that releases a door latch only after a fixed button sequence. The user presses the start button first. Then the user presses the colored buttons in the order red, blue, green, red. Every button input is a level that the block samples on the rising clock edge. The block forms an internal "some colored button is down" signal. Whenever that signal is low, the machine holds its current step, so the user can release a button before pressing the next one. A colored press that does not match the expected color sends the machine back to idle, and the door stays locked.

When the last red press is accepted, the block raises the unlock output for exactly one cycle and then returns to idle. The parameter `STRICT` selects how simultaneous presses are treated. When it is set, two or more colored buttons down at once count as a wrong press. This blocks the trick of holding every button down to pass every step.

Top module: `color_code_lock`

## Requirements
- R1: A synchronous reset (rst=1 at a rising edge) puts the machine in idle, and unlock reads 0 in the following cycle.
- R2: In idle, the machine stays in idle while start is 0, and no colored press ever raises unlock. With start=1 it moves to the first step.
- R3: In any step state, a cycle with no colored button down leaves the step unchanged, so the sequence can continue afterwards.
- R4: The accepted order is red, then blue, then green, then red. After the final red is sampled, unlock is 1 during the next cycle.
- R5: In a step state, a colored press without the expected color returns the machine to idle, and unlock stays 0.
- R6: unlock is high for exactly one cycle. On the edge after that cycle the machine is in idle again, and start is ignored on that edge.
- R7: With STRICT=1, a step cycle with two or more colored buttons down is treated as a wrong press. With STRICT=0, such a cycle advances whenever the expected color is among the buttons down.
- R8: unlock is 1 only in the cycle that follows the accepted final red press. At all other times it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_start | input | 1 | Start button level |
| btn_red | input | 1 | Red button level |
| btn_green | input | 1 | Green button level |
| btn_blue | input | 1 | Blue button level |
| unlock | output | 1 | Door release pulse |

## Verification
The assertions assume that button levels are already clean and synchronous to clk, with one sample per cycle. They also assume that reset is asserted at the start of the run. The random stimulus changes buttons only on the falling edge, so each level holds steady across the edge where it is sampled. Runs that follow the code are built as press and release pairs with random gaps, and wrong, multi-press and start-during-step cycles are mixed in. The bench keeps its own model of the step and flags any unlock that the model does not predict.

// File: rtl/color_code_lock.sv
module color_code_lock #(
  parameter bit STRICT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_start,
  input  logic btn_red,
  input  logic btn_green,
  input  logic btn_blue,
  output logic unlock
);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ARMED = 3'd1,
    S_GOT_R = 3'd2,
    S_GOT_B = 3'd3,
    S_GOT_G = 3'd4,
    S_OPEN  = 3'd5
  } step_t;

  step_t step_q, step_d;

  logic any_press, multi_press;
  logic exp_hit;

  assign any_press   = btn_red | btn_green | btn_blue;
  assign multi_press = (btn_red & btn_green) | (btn_red & btn_blue) | (btn_green & btn_blue);

  always_comb begin
    case (step_q)
      S_ARMED, S_GOT_G: exp_hit = btn_red;
      S_GOT_R:          exp_hit = btn_blue;
      S_GOT_B:          exp_hit = btn_green;
      default:          exp_hit = 1'b0;
    endcase
    if (STRICT && multi_press) exp_hit = 1'b0;
  end

  always_comb begin
    step_d = step_q;
    case (step_q)
      S_IDLE:  step_d = btn_start ? S_ARMED : S_IDLE;
      S_OPEN:  step_d = S_IDLE;
      default: begin
        if (!any_press)   step_d = step_q;
        else if (!exp_hit) step_d = S_IDLE;
        else               step_d = step_t'(step_q + 3'd1);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= S_IDLE;
    else     step_q <= step_d;
  end

  assign unlock = (step_q == S_OPEN);

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !unlock && step_q == S_IDLE);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (step_q == S_IDLE && !btn_start) |=> step_q == S_IDLE);

  p_step_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (step_q != S_IDLE && step_q != S_OPEN && !any_press) |=> $stable(step_q));

  p_wrong_abort_r5: assert property (@(posedge clk) disable iff (rst)
    (step_q == S_GOT_R && any_press && !btn_blue) |=> step_q == S_IDLE);

  p_pulse_once_r6: assert property (@(posedge clk) disable iff (rst)
    unlock |=> !unlock && step_q == S_IDLE);

  generate
    if (STRICT) begin : g_strict
      p_multi_reject_r7: assert property (@(posedge clk) disable iff (rst)
        (step_q != S_IDLE && step_q != S_OPEN && $countones({btn_red, btn_green, btn_blue}) > 1)
        |=> step_q == S_IDLE);
    end
  endgenerate

  p_open_source_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock) |-> $past(step_q) == S_GOT_G && $past(btn_red));

endmodule

// File: tb/sim_color_code_lock.sv
module sim_color_code_lock;
  logic clk = 1'b0, rst = 1'b1;
  logic s = 0, r = 0, g = 0, b = 0;
  logic unlock;
  int checks = 0, fails = 0;
  int mstep = 0;
  bit done = 0;

  color_code_lock #(.STRICT(1'b1)) u0 (
    .clk(clk), .rst(rst), .btn_start(s), .btn_red(r),
    .btn_green(g), .btn_blue(b), .unlock(unlock));

  always #4 clk = ~clk;

  function automatic int next_step(int st, bit ss, bit rr, bit gg, bit bb);
    bit any, hit;
    any = rr | gg | bb;
    if (st == 0) return ss ? 1 : 0;
    if (st == 5) return 0;
    if (!any) return st;
    case (st)
      1, 4: hit = rr;
      2: hit = bb;
      default: hit = gg;
    endcase
    if ((int'(rr) + int'(gg) + int'(bb)) > 1) hit = 0;
    return hit ? st + 1 : 0;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s unlock=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc(bit ss, bit rr, bit gg, bit bb, string req);
    s = ss; r = rr; g = gg; b = bb;
    @(posedge clk);
    mstep = next_step(mstep, ss, rr, gg, bb);
    @(negedge clk);
    chk(req, unlock, mstep == 5);
  endtask

  task automatic code(string req);
    cyc(1,0,0,0,req); cyc(0,0,0,0,req);
    cyc(0,1,0,0,req); cyc(0,0,0,0,req);
    cyc(0,0,0,1,req); cyc(0,0,0,0,req);
    cyc(0,0,1,0,req); cyc(0,0,0,0,req);
    cyc(0,1,0,0,req);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog unlock=%0b expected=done", unlock);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    rst = 0; mstep = 0;
    chk("R1 reset", unlock, 1'b0);
    // R4 clean sequence, then R6 one-cycle pulse with start ignored
    code("R4 sequence");
    chk("R4 unlock", unlock, 1'b1);
    cyc(1,0,0,0,"R6 pulse end");
    chk("R6 idle after", unlock, 1'b0);
    // R2 colored presses in idle do nothing
    cyc(0,1,1,1,"R2 idle"); cyc(0,1,0,0,"R2 idle"); cyc(0,0,0,1,"R2 idle");
    // R3 hold with long gaps
    cyc(1,0,0,0,"R3");
    for (int i = 0; i < 5; i++) cyc(0,0,0,0,"R3 hold");
    cyc(0,1,0,0,"R3"); cyc(0,0,0,0,"R3"); cyc(0,0,0,1,"R3");
    cyc(0,0,1,0,"R3"); cyc(0,0,0,0,"R3"); cyc(0,1,0,0,"R3");
    chk("R3 unlock", unlock, 1'b1);
    cyc(0,0,0,0,"R6");
    // R5 wrong color aborts
    cyc(1,0,0,0,"R5"); cyc(0,1,0,0,"R5"); cyc(0,0,1,0,"R5 wrong");
    cyc(0,0,0,1,"R5"); cyc(0,0,1,0,"R5"); cyc(0,1,0,0,"R5 no open");
    chk("R5 locked", unlock, 1'b0);
    // R7 all buttons held
    cyc(1,0,0,0,"R7");
    for (int i = 0; i < 4; i++) cyc(0,1,1,1,"R7 multi");
    chk("R7 locked", unlock, 1'b0);
    // R1 reset mid-sequence
    cyc(1,0,0,0,"R1"); cyc(0,1,0,0,"R1");
    rst = 1; @(posedge clk); mstep = 0; @(negedge clk); rst = 0;
    cyc(0,0,0,1,"R1 after reset"); cyc(0,0,1,0,"R1"); cyc(0,1,0,0,"R1");
    chk("R1 locked", unlock, 1'b0);
    // R8 random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0) code("R8 rnd code");
      else begin
        int k;
        k = $urandom_range(0, 15);
        if (k < 6) cyc(k == 0, 0, 0, 0, "R8 rnd");
        else cyc($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1), "R8 rnd");
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule